// File: doc/BRIEF.md
# Control Register Bank with Atomic Bit Aliases

This block is the register file that sits in front of a peripheral's protocol engines. It holds a small set of 32-bit registers: a control word, a command word and an argument word. Each register occupies a 16-byte window. Within that window the low address bits pick how a write acts on the stored value. The write can replace the value, OR bits into it, clear bits from it, or invert bits in it. Software can therefore change single bits without a read-modify-write sequence. Every address in a window reads back the current value of that register.

The control word carries three bits with fixed meaning. Bit 31 requests a soft reset. Bit 30 gates the unit's clock. Bit 29 marks a running transaction. A soft reset holds bit 31 high for a fixed number of cycles. It then returns every register to its reset value, and bit 31 drops by itself, which is what software polls for. A soft reset cannot be requested while the clock gate bit still reads 1. The engine behind the bank ends a transaction by pulsing a completion input, and that pulse clears the run bit.

Top module: `mci_regbank`

## Requirements
- R1: After the external reset the control register reads 0x4000_0000 (clock gate set) and the command and argument registers read 0.
- R2: A write whose address bits [3:2] are 0 replaces the whole value of the register picked by address bits [7:4] (0 = control, 1 = command, 2 = argument).
- R3: A write with address bits [3:2] = 1 sets exactly the bits written as 1 and leaves the others unchanged.
- R4: A write with address bits [3:2] = 2 clears exactly the bits written as 1 and leaves the others unchanged.
- R5: A write with address bits [3:2] = 3 inverts exactly the bits written as 1 and leaves the others unchanged.
- R6: A read returns the register's current value at all four alias addresses of its window. A window index of NUM_REGS or above reads 0, and writes to it change no register.
- R7: Once control bit 31 becomes 1, it reads 1 for exactly SRST_CYCLES (default 4) cycles. In the following cycle every register holds its R1 value.
- R8: Bus writes that arrive while control bit 31 reads 1 change no register.
- R9: A write that would set control bit 31 while control bit 30 currently reads 1 leaves bit 31 at 0. Its other bits still take effect.
- R10: A cycle with run_done high clears control bit 29 at the next edge. This takes priority over a software write in the same cycle that sets the bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Byte address: [7:4] register window, [3:2] alias operation |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Read data for bus_addr, same cycle |
| run_done | input | 1 | Completion pulse from the engine, clears the run bit |
| regs_o | output | NUM_REGS*32 | All register values, register i at bits [32*i+31:32*i] |

## Verification
The command register is driven through all four alias operations in turn, with data patterns chosen so that each step changes bits the previous one left alone. A wrong operation, or one applied to the wrong bits, therefore gives a distinct value. Reads at every alias address of one window, plus a write and read at an unmapped window, separate the read decode from the write decode. The soft reset is started once with the gate set and once with it cleared. A write dropped into the middle of the sequence shows the exact cycle in which bit 31 falls, and shows that the write was ignored. The completion pulse is applied alone and together with a set-alias write of the run bit, to expose the priority between them.

// File: rtl/mci_regbank_pkg.sv
package mci_regbank_pkg;

  localparam int unsigned DATA_W    = 32;
  localparam int unsigned CTRL_IDX  = 0;
  localparam int unsigned SRST_BIT  = 31;
  localparam int unsigned GATE_BIT  = 30;
  localparam int unsigned RUN_BIT   = 29;

  // alias operation encoded in address bits [3:2]
  typedef enum logic [1:0] {
    OP_WRITE  = 2'd0,
    OP_SET    = 2'd1,
    OP_CLEAR  = 2'd2,
    OP_TOGGLE = 2'd3
  } alias_op_e;

  function automatic logic [DATA_W-1:0] reg_reset_value(input int unsigned idx);
    logic [DATA_W-1:0] v;
    v = '0;
    if (idx == CTRL_IDX) v[GATE_BIT] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/regbank_decode.sv
module regbank_decode
  import mci_regbank_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned NUM_REGS = 3,
  localparam int unsigned IDX_W   = ADDR_W - 4
) (
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                we_i,
  output logic [IDX_W-1:0]    idx_o,
  output alias_op_e           op_o,
  output logic                hit_o,
  output logic [NUM_REGS-1:0] wr_sel_o
);

  logic unused_low;
  assign unused_low = ^addr_i[1:0];

  assign idx_o = addr_i[ADDR_W-1:4];
  assign op_o  = alias_op_e'(addr_i[3:2]);
  assign hit_o = ({1'b0, idx_o} < (IDX_W+1)'(NUM_REGS));

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
    assign wr_sel_o[g] = we_i && hit_o && (idx_o == IDX_W'(g));
  end

endmodule

// File: rtl/regbank_alias_merge.sv
module regbank_alias_merge
  import mci_regbank_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] old_i,
  input  logic [W-1:0] wdata_i,
  input  alias_op_e    op_i,
  output logic [W-1:0] merged_o
);

  always_comb begin
    unique case (op_i)
      OP_WRITE:  merged_o = wdata_i;
      OP_SET:    merged_o = old_i | wdata_i;
      OP_CLEAR:  merged_o = old_i & ~wdata_i;
      OP_TOGGLE: merged_o = old_i ^ wdata_i;
      default:   merged_o = old_i;
    endcase
  end

endmodule

// File: rtl/regbank_srst_seq.sv
module regbank_srst_seq #(
  parameter int unsigned SRST_CYCLES = 4,
  localparam int unsigned CNT_W      = $clog2(SRST_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_i,
  output logic done_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign done_o = busy_i && (cnt_q == CNT_W'(SRST_CYCLES - 1));

  always_comb begin
    cnt_en = busy_i || (cnt_q != '0);
    if (!busy_i || done_o) cnt_d = '0;
    else                   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/mci_regbank.sv
module mci_regbank
  import mci_regbank_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned NUM_REGS    = 3,
  parameter int unsigned SRST_CYCLES = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  input  logic                       bus_we,
  output logic [DATA_W-1:0]          bus_rdata,
  input  logic                       run_done,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);

  localparam int unsigned IDX_W = ADDR_W - 4;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  // address decode
  logic [IDX_W-1:0]    idx;
  alias_op_e           op;
  logic                hit;
  logic [NUM_REGS-1:0] wr_sel;

  regbank_decode #(
    .ADDR_W   (ADDR_W),
    .NUM_REGS (NUM_REGS)
  ) u_decode (
    .addr_i   (bus_addr),
    .we_i     (bus_we),
    .idx_o    (idx),
    .op_o     (op),
    .hit_o    (hit),
    .wr_sel_o (wr_sel)
  );

  // soft-reset sequencing
  logic [NUM_REGS*DATA_W-1:0] reg_flat;
  logic                       srst_busy;
  logic                       srst_done;

  assign srst_busy = reg_flat[CTRL_IDX*DATA_W + SRST_BIT];

  regbank_srst_seq #(
    .SRST_CYCLES (SRST_CYCLES)
  ) u_srst (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .busy_i (srst_busy),
    .done_o (srst_done)
  );

  // register storage
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [DATA_W-1:0] q;
    logic [DATA_W-1:0] merged;
    logic [DATA_W-1:0] nxt;
    logic              en;

    regbank_alias_merge #(
      .W (DATA_W)
    ) u_merge (
      .old_i    (q),
      .wdata_i  (bus_wdata),
      .op_i     (op),
      .merged_o (merged)
    );

    if (g == CTRL_IDX) begin : g_ctrl
      always_comb begin
        nxt = q;
        en  = 1'b0;
        if (srst_done) begin
          nxt = reg_reset_value(g);
          en  = 1'b1;
        end else begin
          if (wr_sel[g] && !srst_busy) begin
            nxt = merged;
            en  = 1'b1;
            if (q[GATE_BIT]) nxt[SRST_BIT] = 1'b0;
          end
          if (run_done) begin
            nxt[RUN_BIT] = 1'b0;
            en           = 1'b1;
          end
        end
      end
    end else begin : g_data
      always_comb begin
        nxt = q;
        en  = 1'b0;
        if (srst_done) begin
          nxt = reg_reset_value(g);
          en  = 1'b1;
        end else if (wr_sel[g] && !srst_busy) begin
          nxt = merged;
          en  = 1'b1;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) q <= reg_reset_value(g);
      else if (en)     q <= nxt;
    end

    assign reg_flat[g*DATA_W +: DATA_W] = q;
  end

  // read path, same cycle
  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (hit && (idx == IDX_W'(i))) bus_rdata = reg_flat[i*DATA_W +: DATA_W];
    end
  end

  assign regs_o = reg_flat;

endmodule

// File: rtl/mci_regbank_chk.sv
module mci_regbank_chk #(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned NUM_REGS    = 3,
  parameter int unsigned SRST_CYCLES = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [ADDR_W-1:0]      bus_addr,
  input logic [31:0]            bus_wdata,
  input logic                   bus_we,
  input logic [31:0]            bus_rdata,
  input logic                   run_done,
  input logic [NUM_REGS*32-1:0] regs_o
);

  localparam int unsigned IDX_W = ADDR_W - 4;
  localparam int unsigned HC_W  = $clog2(SRST_CYCLES + 2);

  logic [31:0] ctrl, cmd;
  assign ctrl = regs_o[31:0];
  assign cmd  = regs_o[63:32];

  logic [HC_W-1:0] hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hi_cnt <= '0;
    else if (ctrl[31]) hi_cnt <= hi_cnt + 1'b1;
    else              hi_cnt <= '0;
  end

  // R7
  srst_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[31] |-> (hi_cnt < HC_W'(SRST_CYCLES)));

  // R7
  srst_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl[31]) |-> (hi_cnt == HC_W'(SRST_CYCLES)) && (ctrl == 32'h4000_0000) && (cmd == 32'h0));

  // R8
  srst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[31] && $past(ctrl[31])) |-> $stable(cmd));

  // R9
  gate_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[30] && !ctrl[31]) |=> !ctrl[31]);

  // R10
  run_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_done |=> !ctrl[29]);

  // R3
  set_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !ctrl[31] && bus_addr == {IDX_W'(1), 2'b01, 2'b00})
      |=> ((cmd & $past(bus_wdata)) == $past(bus_wdata)));

  // R4
  clear_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !ctrl[31] && bus_addr == {IDX_W'(1), 2'b10, 2'b00})
      |=> ((cmd & $past(bus_wdata)) == 32'h0));

  // R6
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, bus_addr[ADDR_W-1:4]} >= (IDX_W+1)'(NUM_REGS)) |-> (bus_rdata == 32'h0));

endmodule

bind mci_regbank mci_regbank_chk #(
  .ADDR_W      (ADDR_W),
  .NUM_REGS    (NUM_REGS),
  .SRST_CYCLES (SRST_CYCLES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_we    (bus_we),
  .bus_rdata (bus_rdata),
  .run_done  (run_done),
  .regs_o    (regs_o)
);

// File: tb/mci_regbank_test.sv
module mci_regbank_test;

  logic        clk;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_we;
  logic [31:0] bus_rdata;
  logic        run_done;
  logic [95:0] regs_o;

  int checks;
  int errors;
  bit finished;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] cur_exp;
  string       cur_tag;

  mci_regbank uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .run_done  (run_done),
    .regs_o    (regs_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // monitor: compare the queued expectation with the read data mid-cycle
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      cur_exp = exp_q.pop_front();
      cur_tag = tag_q.pop_front();
      checks++;
      if (bus_rdata !== cur_exp) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", cur_tag, bus_rdata, cur_exp);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic done);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_we = 1'b1; run_done = done;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input logic done, input string t);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = '0; bus_we = 1'b0; run_done = done;
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; finished = 1'b0;
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0; run_done = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);

    rd(8'h00, 32'h4000_0000, 0, "R1 ctrl reset");
    rd(8'h10, 32'h0000_0000, 0, "R1 cmd reset");
    rd(8'h20, 32'h0000_0000, 0, "R1 arg reset");

    // gate still set: soft reset request blocked
    wr(8'h04, 32'h8000_0010, 0);
    rd(8'h00, 32'h4000_0010, 0, "R9 srst blocked, other bit set");
    rd(8'h00, 32'h4000_0010, 0, "R9 no late srst");

    wr(8'h10, 32'hDEAD_BEEF, 0);
    rd(8'h10, 32'hDEAD_BEEF, 0, "R2 base write");
    wr(8'h10, 32'h0000_00A5, 0);
    rd(8'h10, 32'h0000_00A5, 0, "R2 base replaces");
    wr(8'h14, 32'h0000_0F00, 0);
    rd(8'h10, 32'h0000_0FA5, 0, "R3 set alias");
    wr(8'h18, 32'h0000_0005, 0);
    rd(8'h10, 32'h0000_0FA0, 0, "R4 clear alias");
    wr(8'h1C, 32'h0000_00FF, 0);
    rd(8'h10, 32'h0000_0F5F, 0, "R5 toggle alias");
    rd(8'h14, 32'h0000_0F5F, 0, "R6 read at set alias");
    rd(8'h18, 32'h0000_0F5F, 0, "R6 read at clear alias");
    rd(8'h1C, 32'h0000_0F5F, 0, "R6 read at toggle alias");

    wr(8'h20, 32'h1234_5678, 0);
    rd(8'h24, 32'h1234_5678, 0, "R2 arg write, R6 alias read");
    wr(8'h30, 32'hFFFF_FFFF, 0);
    rd(8'h30, 32'h0000_0000, 0, "R6 unmapped reads 0");
    rd(8'h10, 32'h0000_0F5F, 0, "R6 unmapped write leaves cmd");
    rd(8'h20, 32'h1234_5678, 0, "R6 unmapped write leaves arg");

    // run bit and completion
    wr(8'h00, 32'h2000_0000, 0);
    rd(8'h00, 32'h2000_0000, 0, "R2 ctrl write run");
    rd(8'h00, 32'h2000_0000, 1, "R10 run before edge");
    rd(8'h00, 32'h0000_0000, 0, "R10 run cleared by done");
    wr(8'h04, 32'h2000_0000, 1);
    rd(8'h00, 32'h0000_0000, 0, "R10 done beats set");

    // soft reset with gate clear
    wr(8'h04, 32'h0000_0001, 0);
    rd(8'h00, 32'h0000_0001, 0, "R3 ctrl set");
    wr(8'h04, 32'h8000_0000, 0);
    rd(8'h00, 32'h8000_0001, 0, "R7 srst cycle 1");
    wr(8'h10, 32'h1111_1111, 0);
    rd(8'h00, 32'h8000_0001, 0, "R7 srst cycle 3");
    rd(8'h10, 32'h0000_0F5F, 0, "R8 write ignored during srst");
    rd(8'h00, 32'h4000_0000, 0, "R7 ctrl after srst");
    rd(8'h10, 32'h0000_0000, 0, "R7 cmd after srst");
    rd(8'h20, 32'h0000_0000, 0, "R7 arg after srst");

    @(posedge clk); #1 bus_we = 1'b0; run_done = 1'b0;
    repeat (2) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule